// File: doc/BRIEF.md
# In-band loopback code generator

This block sits in the serial data path of a line interface. Under software control it can replace the normal bit stream with a loopback code that repeats without a break. There are two codes. The activate code asks the far end to close a loop, and the deactivate code asks it to open the loop again. Each code has its own pattern register and its own length, which can be 5 to 8 bits.

A direction input decides whether the code goes into the receive stream or the transmit stream. The other stream always passes through unchanged. Data advances one bit on each cycle in which the bit strobe is high. Both output streams are registered, so the block adds one strobe of latency whether a code is being inserted or not.

Software programs the block through a small register port with three registers:

| Address | Register | Contents |
|---|---|---|
| 0 | Control | bits [7:6] deactivate length, bits [5:4] activate length, bit 1 send deactivate, bit 0 send activate. Bits [3:2] read as 0. Reset value 0x40. |
| 1 | Activate pattern | 8 bits. Reset value 0x00. |
| 2 | Deactivate pattern | 8 bits. Reset value 0x00. |

A code shorter than 5 bits is sent by choosing a length that is a multiple of the wanted length and writing the short pattern repeated into the pattern register.

Top module: `lbc_gen`

## Requirements
- R1: After reset the control register reads 0x40, both pattern registers read 0x00, and `rx_out` and `tx_out` are 0.
- R2: The deactivate length field is control bits [7:6]. The codes 00, 01, 10 and 11 give lengths of 5, 6, 7 and 8 bits. Its reset value is 01 (6 bits).
- R3: The activate length field is control bits [5:4]. It uses the same encoding as R2. Its reset value is 00 (5 bits).
- R4: While control bit 1 is 1, control bit 0 is 0 and `prbs_on` is 0, each strobe sends the next bit of the deactivate code on the target stream. The code is the N low bits of the deactivate pattern, sent from bit N-1 down to bit 0 and then repeated. It continues until the bit is cleared.
- R5: While control bit 0 is 1, control bit 1 is 0 and `prbs_on` is 0, the activate pattern is sent in the same way as R4, using the activate length.
- R6: When both send bits are 1, or `prbs_on` is 1, no code is inserted and both streams pass through unchanged.
- R7: When `dir_sel` is 0 the code goes into the receive stream (`rx_out`), and when it is 1 the code goes into the transmit stream (`tx_out`). The other stream always carries its input unchanged.
- R8: A code that becomes enabled starts from its first bit. A write to its length or pattern while it is being sent takes effect only at the next pattern boundary.
- R9: Each output updates only on a strobe, to the value chosen from the inputs present at that strobe. This is a fixed latency of one strobe, and the outputs hold their value between strobes.
- R10: A short pattern written repeatedly into a longer length is sent with the period of the short pattern and needs no special handling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 activate pattern, 2 deactivate pattern |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Contents of the addressed register (combinational) |
| bit_en | input | 1 | One-bit-per-cycle data strobe |
| dir_sel | input | 1 | Target stream: 0 receive, 1 transmit |
| prbs_on | input | 1 | PRBS generator active; blocks code insertion |
| rx_in | input | 1 | Receive stream input |
| tx_in | input | 1 | Transmit stream input |
| rx_out | output | 1 | Receive stream output, registered |
| tx_out | output | 1 | Transmit stream output, registered |

## Verification
The bench builds the block with the default 8-bit pattern width. With this width, all four length codes (5 to 8 bits) can be reached for both codes and in both directions. A behavioural queue model predicts both output streams on every clock while the strobe is irregular. This exposes bit-order, wrap-point and latency faults. Directed phases change the pattern and the length in the middle of a pattern, toggle the enables, raise `prbs_on` and set both enables, to reach the boundary-update and blocking rules.

// File: rtl/lbc_pkg.sv
package lbc_pkg;
  localparam int unsigned REG_W  = 8;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned LEN_W  = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_UP   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_DN   = 2'd2;

  typedef struct packed {
    logic [LEN_W-1:0] dn_len;
    logic [LEN_W-1:0] up_len;
    logic [1:0]       rsvd;
    logic             send_dn;
    logic             send_up;
  } ctrl_t;

  localparam logic [REG_W-1:0] CTRL_RESET = 8'h40;
  localparam logic [REG_W-1:0] CTRL_WMASK = 8'hF3;
endpackage

// File: rtl/lbc_regs.sv
module lbc_regs
  import lbc_pkg::*;
#(
  parameter int unsigned PAT_W = REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output ctrl_t             ctrl,
  output logic [PAT_W-1:0]  pat_up,
  output logic [PAT_W-1:0]  pat_dn
);
  ctrl_t            ctrl_q, ctrl_d;
  logic [PAT_W-1:0] up_q, up_d, dn_q, dn_d;
  logic             wr_ctrl, wr_up, wr_dn;

  always_comb begin
    wr_ctrl = we && (addr == ADDR_CTRL);
    wr_up   = we && (addr == ADDR_UP);
    wr_dn   = we && (addr == ADDR_DN);
    ctrl_d  = wr_ctrl ? ctrl_t'(wdata & CTRL_WMASK) : ctrl_q;
    up_d    = wr_up ? wdata[PAT_W-1:0] : up_q;
    dn_d    = wr_dn ? wdata[PAT_W-1:0] : dn_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= ctrl_t'(CTRL_RESET);
      up_q   <= '0;
      dn_q   <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      up_q   <= up_d;
      dn_q   <= dn_d;
    end
  end

  always_comb begin
    case (addr)
      ADDR_CTRL: rdata = ctrl_q;
      ADDR_UP:   rdata = REG_W'(up_q);
      ADDR_DN:   rdata = REG_W'(dn_q);
      default:   rdata = '0;
    endcase
  end

  assign ctrl   = ctrl_q;
  assign pat_up = up_q;
  assign pat_dn = dn_q;
endmodule

// File: rtl/lbc_seq.sv
module lbc_seq #(
  parameter int unsigned PAT_W = 8,
  parameter int unsigned LEN_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             active,
  input  logic [LEN_W-1:0] len_code,
  input  logic [PAT_W-1:0] pattern,
  output logic             code_bit
);
  localparam int unsigned     CNT_W   = $clog2(PAT_W);
  localparam logic [CNT_W-1:0] BASE_M1 = CNT_W'(PAT_W - 4);

  logic [CNT_W-1:0] cnt_q, cnt_d, len_m1, idx;
  logic [PAT_W-1:0] sh_pat_q, sh_pat_d, use_pat;
  logic [LEN_W-1:0] sh_len_q, sh_len_d, use_len;
  logic             at_start;

  // At a boundary the live registers are used and captured; in mid-pattern the captured copy is used.
  always_comb begin
    at_start = (cnt_q == '0);
    use_pat  = at_start ? pattern  : sh_pat_q;
    use_len  = at_start ? len_code : sh_len_q;
    len_m1   = BASE_M1 + CNT_W'(use_len);
    idx      = len_m1 - cnt_q;
    code_bit = use_pat[idx];

    cnt_d    = cnt_q;
    sh_pat_d = sh_pat_q;
    sh_len_d = sh_len_q;
    if (!active) begin
      cnt_d = '0;
    end else if (bit_en) begin
      cnt_d = (cnt_q == len_m1) ? '0 : cnt_q + 1'b1;
      if (at_start) begin
        sh_pat_d = pattern;
        sh_len_d = len_code;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      sh_pat_q <= '0;
      sh_len_q <= '0;
    end else begin
      cnt_q    <= cnt_d;
      sh_pat_q <= sh_pat_d;
      sh_len_q <= sh_len_d;
    end
  end
endmodule

// File: rtl/lbc_gen.sv
module lbc_gen
  import lbc_pkg::*;
#(
  parameter int unsigned PAT_W = REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              bit_en,
  input  logic              dir_sel,
  input  logic              prbs_on,
  input  logic              rx_in,
  input  logic              tx_in,
  output logic              rx_out,
  output logic              tx_out
);
  localparam int unsigned NCODE = 2;  // index 0 activate, 1 deactivate

  logic [1:0]       rst_sync_q;
  logic             rst_sync_n;
  ctrl_t            ctrl;
  logic [PAT_W-1:0] pat_up, pat_dn;
  logic             send_up, send_dn;
  logic [NCODE-1:0] act, cbit;
  logic [LEN_W-1:0] len_sel [NCODE];
  logic [PAT_W-1:0] pat_sel [NCODE];
  logic             ins, code, rx_d, tx_d, rx_q, tx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  lbc_regs #(.PAT_W(PAT_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (reg_we),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .ctrl  (ctrl),
    .pat_up(pat_up),
    .pat_dn(pat_dn)
  );

  assign send_up = ctrl.send_up;
  assign send_dn = ctrl.send_dn;

  always_comb begin
    act[0]     = send_up && !send_dn && !prbs_on;
    act[1]     = send_dn && !send_up && !prbs_on;
    len_sel[0] = ctrl.up_len;
    len_sel[1] = ctrl.dn_len;
    pat_sel[0] = pat_up;
    pat_sel[1] = pat_dn;
  end

  for (genvar g = 0; g < NCODE; g++) begin : g_seq
    lbc_seq #(.PAT_W(PAT_W), .LEN_W(LEN_W)) u_seq (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .bit_en  (bit_en),
      .active  (act[g]),
      .len_code(len_sel[g]),
      .pattern (pat_sel[g]),
      .code_bit(cbit[g])
    );
  end

  always_comb begin
    ins  = |act;
    code = act[0] ? cbit[0] : cbit[1];
    rx_d = rx_q;
    tx_d = tx_q;
    if (bit_en) begin
      rx_d = (ins && !dir_sel) ? code : rx_in;
      tx_d = (ins &&  dir_sel) ? code : tx_in;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rx_q <= 1'b0;
      tx_q <= 1'b0;
    end else begin
      rx_q <= rx_d;
      tx_q <= tx_d;
    end
  end

  assign rx_out = rx_q;
  assign tx_out = tx_q;
endmodule

// File: rtl/lbc_chk.sv
module lbc_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic dir_sel,
  input logic prbs_on,
  input logic rx_in,
  input logic tx_in,
  input logic rx_out,
  input logic tx_out,
  input logic send_up,
  input logic send_dn
);
  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> ($stable(rx_out) && $stable(tx_out))); // R9

  AST_PRBS_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && prbs_on) |=> (rx_out == $past(rx_in) && tx_out == $past(tx_in))); // R6

  AST_BOTH_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && send_up && send_dn) |=> (rx_out == $past(rx_in) && tx_out == $past(tx_in))); // R6

  AST_RX_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && dir_sel) |=> (rx_out == $past(rx_in))); // R7

  AST_TX_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !dir_sel) |=> (tx_out == $past(tx_in))); // R7

  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !send_up && !send_dn) |=> (rx_out == $past(rx_in) && tx_out == $past(tx_in))); // R9
endmodule

bind lbc_gen lbc_chk i_chk (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .bit_en (bit_en),
  .dir_sel(dir_sel),
  .prbs_on(prbs_on),
  .rx_in  (rx_in),
  .tx_in  (tx_in),
  .rx_out (rx_out),
  .tx_out (tx_out),
  .send_up(send_up),
  .send_dn(send_dn)
);

// File: tb/test_lbc_gen.sv
module test_lbc_gen;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_we;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       bit_en, dir_sel, prbs_on, rx_in, tx_in, rx_out, tx_out;

  always #5 clk = ~clk;

  lbc_gen i_lbc_gen (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bit_en(bit_en),
    .dir_sel(dir_sel), .prbs_on(prbs_on), .rx_in(rx_in), .tx_in(tx_in),
    .rx_out(rx_out), .tx_out(tx_out)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 0;
  string cur_req = "R9";

  logic [7:0] m_ctrl, m_up, m_dn;
  bit         q_up[$];
  bit         q_dn[$];
  logic       m_rx, m_tx;

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // One clock: predict from present inputs and registers, then compare after the edge.
  task automatic tick();
    bit au, ad, b;
    int l;
    au = m_ctrl[0] && !m_ctrl[1] && !prbs_on;
    ad = m_ctrl[1] && !m_ctrl[0] && !prbs_on;
    if (!au) q_up.delete();
    if (!ad) q_dn.delete();
    if (bit_en) begin
      b = 1'b0;
      if (au) begin
        if (q_up.size() == 0) begin
          l = 5 + int'(m_ctrl[5:4]);
          for (int i = l - 1; i >= 0; i--) q_up.push_back(m_up[i]);
        end
        b = q_up.pop_front();
      end
      if (ad) begin
        if (q_dn.size() == 0) begin
          l = 5 + int'(m_ctrl[7:6]);
          for (int i = l - 1; i >= 0; i--) q_dn.push_back(m_dn[i]);
        end
        b = q_dn.pop_front();
      end
      m_rx = ((au || ad) && !dir_sel) ? b : rx_in;
      m_tx = ((au || ad) &&  dir_sel) ? b : tx_in;
    end
    if (reg_we) begin
      case (reg_addr)
        2'd0: m_ctrl = reg_wdata & 8'hF3;
        2'd1: m_up   = reg_wdata;
        2'd2: m_dn   = reg_wdata;
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    check(cur_req, "rx_out", {7'd0, rx_out}, {7'd0, m_rx});
    check(cur_req, "tx_out", {7'd0, tx_out}, {7'd0, m_tx});
    reg_we = 1'b0;
  endtask

  task automatic stim(input bit always_strobe);
    bit_en = always_strobe ? 1'b1 : 1'($urandom_range(0, 1));
    rx_in  = 1'($urandom_range(0, 1));
    tx_in  = 1'($urandom_range(0, 1));
  endtask

  task automatic run(input int n, input bit always_strobe);
    for (int i = 0; i < n; i++) begin
      stim(always_strobe);
      tick();
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_we    = 1'b1;
    reg_addr  = a;
    reg_wdata = d;
    stim(1'b0);
    tick();
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string req);
    reg_addr = a;
    #1;
    check(req, "reg_rdata", reg_rdata, exp);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL R9 watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = 2'd0; reg_wdata = 8'h00;
    bit_en = 1'b0; dir_sel = 1'b0; prbs_on = 1'b0; rx_in = 1'b0; tx_in = 1'b0;
    m_ctrl = 8'h40; m_up = 8'h00; m_dn = 8'h00; m_rx = 1'b0; m_tx = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state, with R2 and R3 length defaults
    rd(2'd0, 8'h40, "R1,R2,R3");
    rd(2'd1, 8'h00, "R1");
    rd(2'd2, 8'h00, "R1");
    check("R1", "rx_out", {7'd0, rx_out}, 8'd0);
    check("R1", "tx_out", {7'd0, tx_out}, 8'd0);

    // R9 bypass with irregular strobe, both directions
    cur_req = "R9";
    dir_sel = 1'b0; run(40, 1'b0);
    dir_sel = 1'b1; run(40, 1'b0);

    // R2 R4 R7 deactivate code, every length, both directions
    cur_req = "R2,R4,R7";
    wr(2'd2, 8'hA6);
    for (int l = 0; l < 4; l++) begin
      for (int d = 0; d < 2; d++) begin
        dir_sel = 1'(d);
        wr(2'd0, {2'(l), 2'b00, 4'b0010});
        rd(2'd0, {2'(l), 6'b000010}, "R2");
        run(40, 1'b0);
        wr(2'd0, 8'h00);
      end
    end

    // R3 R5 R7 activate code, every length, both directions
    cur_req = "R3,R5,R7";
    wr(2'd1, 8'h9B);
    for (int l = 0; l < 4; l++) begin
      for (int d = 0; d < 2; d++) begin
        dir_sel = 1'(d);
        wr(2'd0, {2'b01, 2'(l), 4'b0001});
        rd(2'd0, {2'b01, 2'(l), 4'b0001}, "R3");
        run(40, 1'b0);
        wr(2'd0, 8'h00);
      end
    end

    // R6 blocking by both enables and by PRBS
    cur_req = "R6";
    dir_sel = 1'b1;
    wr(2'd0, 8'hFF);
    rd(2'd0, 8'hF3, "R6");
    run(30, 1'b0);
    wr(2'd0, 8'h42);
    prbs_on = 1'b1; run(30, 1'b0);
    prbs_on = 1'b0; run(20, 1'b0);
    wr(2'd0, 8'h01);
    prbs_on = 1'b1; run(20, 1'b0);
    prbs_on = 1'b0; wr(2'd0, 8'h00);

    // R8 restart on enable and boundary-timed updates
    cur_req = "R8";
    dir_sel = 1'b0;
    wr(2'd2, 8'h5E);
    wr(2'd0, 8'hC2);
    run(3, 1'b1);
    wr(2'd2, 8'hE1);
    run(10, 1'b1);
    wr(2'd0, 8'h02);
    run(9, 1'b0);
    wr(2'd0, 8'h00);
    run(2, 1'b1);
    wr(2'd0, 8'h82);
    run(4, 1'b0);
    wr(2'd0, 8'h00);
    wr(2'd0, 8'h82);
    run(20, 1'b0);
    dir_sel = 1'b1;
    wr(2'd1, 8'h3C);
    wr(2'd0, 8'h71);
    run(4, 1'b1);
    wr(2'd0, 8'h41);
    run(20, 1'b0);
    wr(2'd0, 8'h00);

    // R10 three-bit code carried in a six-bit length
    cur_req = "R10";
    dir_sel = 1'b1;
    wr(2'd2, 8'h24);
    wr(2'd0, 8'h42);
    run(30, 1'b1);
    wr(2'd0, 8'h00);
    run(4, 1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule